// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a translation miss by walking a hashed page table that sits in ordinary memory. A miss is handed over as a request with the effective address, the access kind (load, store or instruction fetch) and the privilege state. The walker selects one of sixteen segment descriptors with the top four address bits. It derives the access key, the no-execute flag, the direct-store flag and the virtual segment ID from that descriptor, and it forms a hash from the segment ID and the page index. The hash picks a group of eight entries, which the walker scans first in the primary group and then, if needed, in a secondary group addressed by the complemented hash.

Memory is reached through a single 32-bit request port with a valid/ready handshake and at most one read in flight. Writes are posted and return no response. When an entry is selected, the walker sets its referenced bit, and for a permitted store its changed bit, writing the second word back only when a bit changed. The walker then reports one completion pulse carrying either a physical page number with read/write/execute permissions, or a fault flag with a syndrome word. The segment descriptors, the table base and the table mask are plain inputs that are held steady by the surrounding logic. The reset input is asynchronous and active low, and its release is expected to be synchronous to the clock.

Top module: `hpt_walker`

## Requirements
- R1: The descriptor is chosen by address bits [31:28]. Descriptor bit 31 is direct-store, bit 30 is the supervisor key, bit 29 is the user key, bit 28 is no-execute, and bits [23:0] are the segment ID. The access key is 1 when (user and bit 29) or (supervisor and bit 30).
- R2: With hash = segment ID XOR address bits [27:12], entry i of a group is read at base + ((hash << 6) AND mask) + 8*i for the primary pass, using ~hash for the secondary pass. The first word is read first and the second word is read at +4.
- R3: An entry matches when first-word bit 31 is 1, first-word bit 6 equals the pass (0 primary, 1 secondary), and (first word AND 0x7FFFFFBF) equals (segment ID << 7) | (address bits [27:22]). The second word is read only for a matching entry.
- R4: Using pp = second-word bits [1:0], key 0 gives read+write for pp 0, 1 and 2 and read only for pp 3. Key 1 gives nothing for pp 0, read only for pp 1 and 3, and read+write for pp 2. Execute is given when no-execute is clear. A fetch needs execute, a store needs write and a load needs read. The done_perm encoding is bit 0 read, bit 1 write and bit 2 execute.
- R5: The first granting entry ends the search. A match without permission is recorded (the latest one wins) and the scan continues. The secondary group is scanned only when the primary pass produced no grant.
- R6: For the selected entry, the walker sets second-word bit 8 (referenced), and sets bit 7 (changed) only for a granted store. It writes the word back to entry+4 only if it changed. If bit 7 stays clear, the write permission is removed from done_perm.
- R7: Data faults report 0x40000000 for no match and 0x08000000 for a protection violation, with 0x02000000 added for stores.
- R8: Fetches report 0x40000000 for no match and 0x08000000 for a protection violation. A fetch from a no-execute segment faults with 0x10000000 without any memory read.
- R9: A direct-store segment faults without any memory read: fetch 0x10000000, data 0x04000000 plus 0x02000000 for stores.
- R10: req_ready is high only while idle. A memory request is held with a stable address and data until mem_req_ready, and only one read is outstanding.
- R11: After reset, req_ready=1, done_valid=0 and mem_req_valid=0. done_valid is a one-cycle pulse. On success done_ppn is second-word bits [31:12]. On a fault done_ppn and done_perm are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_ea | input | 32 | Effective address of the miss |
| req_store | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access made in user state |
| seg_file | input | 512 | Sixteen 32-bit segment descriptors, slot s at bits [32s+31:32s] |
| tbl_base | input | 32 | Byte address of the page table |
| tbl_mask | input | 32 | Mask applied to the group byte offset |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| done_valid | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Walk ended in a fault |
| done_ppn | output | 20 | Physical page number |
| done_perm | output | 3 | Granted permissions {exec, write, read} |
| done_syndrome | output | 32 | Fault syndrome word |

## Verification
A corrupted scan index or pass bit shows at the memory port within one read: the address of the next request leaves the sequence base + offset + 8*i, or a second pass starts after a grant. It also changes the count of reads before done_valid. A wrong record of a violating entry shows in done_ppn or done_syndrome on the completion pulse. A bad flag computation shows as a missing, extra or wrongly valued write-back word just before that pulse. Because every walk ends in one pulse and the number of reads is fixed by where the entries sit, the checks compare the read count, the first read address, the write count and the write contents together with the result fields.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned PERM_W   = 3;
  localparam int unsigned PERM_RD  = 0;
  localparam int unsigned PERM_WR  = 1;
  localparam int unsigned PERM_EX  = 2;
  localparam int unsigned REF_BIT  = 8;
  localparam int unsigned CHG_BIT  = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_W0,
    ST_RD_W1,
    ST_CHECK,
    ST_WBACK,
    ST_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    FK_NOMATCH,
    FK_PROT,
    FK_NOEXEC,
    FK_DIRECT
  } fault_kind_e;

  // Syndrome word for a fault of a given kind and access type.
  function automatic logic [WORD_W-1:0] fault_syndrome(fault_kind_e kind,
                                                       logic is_fetch,
                                                       logic is_store);
    logic [WORD_W-1:0] s;
    if (is_fetch) begin
      unique case (kind)
        FK_NOMATCH: s = 32'h4000_0000;
        FK_PROT:    s = 32'h0800_0000;
        default:    s = 32'h1000_0000;
      endcase
    end else begin
      unique case (kind)
        FK_NOMATCH: s = 32'h4000_0000;
        FK_PROT:    s = 32'h0800_0000;
        FK_DIRECT:  s = 32'h0400_0000;
        default:    s = 32'h1000_0000;
      endcase
      if (is_store) s = s | 32'h0200_0000;
    end
    return s;
  endfunction

  // Permission set from access key, page protection code and no-execute.
  function automatic logic [PERM_W-1:0] pp_decode(logic key, logic [1:0] pp,
                                                  logic no_exec);
    logic [PERM_W-1:0] p;
    p = '0;
    if (!key) begin
      p[PERM_RD] = 1'b1;
      p[PERM_WR] = (pp != 2'd3);
    end else begin
      p[PERM_RD] = (pp != 2'd0);
      p[PERM_WR] = (pp == 2'd2);
    end
    p[PERM_EX] = ~no_exec;
    return p;
  endfunction

endpackage

// File: rtl/hpt_seg_decode.sv
module hpt_seg_decode #(
  parameter int unsigned EA_W    = 32,
  parameter int unsigned PG_BITS = 12,
  parameter int unsigned SEG_W   = 4,
  parameter int unsigned VSID_W  = 24
) (
  input  logic [31:0]       desc,
  input  logic [EA_W-1:0]   ea,
  input  logic              user,
  output logic              key,
  output logic              no_exec,
  output logic              direct,
  output logic [VSID_W-1:0] hash,
  output logic [31:0]       tag
);
  localparam int unsigned PIDX_W = EA_W - SEG_W - PG_BITS;
  localparam int unsigned API_W  = 6;

  logic [VSID_W-1:0] vsid;
  logic [PIDX_W-1:0] pidx;

  assign vsid    = desc[VSID_W-1:0];
  assign pidx    = ea[EA_W-SEG_W-1:PG_BITS];
  assign direct  = desc[31];
  assign no_exec = desc[28];
  assign key     = (user & desc[29]) | (~user & desc[30]);
  assign hash    = vsid ^ VSID_W'(pidx);
  assign tag     = {1'b0, vsid[23:0], 1'b0, pidx[PIDX_W-1 -: API_W]};

endmodule

// File: rtl/hpt_pte_eval.sv
module hpt_pte_eval
  import hpt_pkg::*;
(
  input  logic [31:0]       w0,
  input  logic [31:0]       w1,
  input  logic              pass,
  input  logic [31:0]       tag,
  input  logic              key,
  input  logic              no_exec,
  input  logic              is_fetch,
  input  logic              is_store,
  output logic              match,
  output logic [PERM_W-1:0] perm,
  output logic              grant
);
  localparam logic [31:0] TAG_MASK = 32'h7FFF_FFBF;

  assign match = w0[31] & (w0[6] == pass) & ((w0 & TAG_MASK) == tag);
  assign perm  = pp_decode(key, w1[1:0], no_exec);

  always_comb begin
    if (is_fetch)      grant = perm[PERM_EX];
    else if (is_store) grant = perm[PERM_WR];
    else               grant = perm[PERM_RD];
  end

endmodule

// File: rtl/hpt_flag_update.sv
module hpt_flag_update
  import hpt_pkg::*;
(
  input  logic [31:0]       w1_old,
  input  logic              is_store,
  input  logic              granted,
  input  logic [PERM_W-1:0] perm_in,
  output logic [31:0]       w1_new,
  output logic              need_write,
  output logic [PERM_W-1:0] perm_out
);
  logic set_chg;

  assign set_chg = is_store & granted & ~w1_old[CHG_BIT];

  always_comb begin
    w1_new          = w1_old;
    w1_new[REF_BIT] = 1'b1;
    if (set_chg) w1_new[CHG_BIT] = 1'b1;
    perm_out = perm_in;
    if (!w1_new[CHG_BIT]) perm_out[PERM_WR] = 1'b0;
  end

  assign need_write = (w1_new != w1_old);

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int unsigned N_SEGS      = 16,
  parameter int unsigned N_ENTRIES   = 8,
  parameter int unsigned ENTRY_BYTES = 8,
  parameter int unsigned PG_BITS     = 12,
  parameter int unsigned VSID_W      = 24,
  parameter int unsigned PPN_W       = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [31:0]            req_ea,
  input  logic                   req_store,
  input  logic                   req_fetch,
  input  logic                   req_user,
  input  logic [N_SEGS*32-1:0]   seg_file,
  input  logic [31:0]            tbl_base,
  input  logic [31:0]            tbl_mask,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic                   mem_req_write,
  output logic [31:0]            mem_req_addr,
  output logic [31:0]            mem_req_wdata,
  input  logic                   mem_rsp_valid,
  input  logic [31:0]            mem_rsp_rdata,
  output logic                   done_valid,
  output logic                   done_fault,
  output logic [PPN_W-1:0]       done_ppn,
  output logic [PERM_W-1:0]      done_perm,
  output logic [31:0]            done_syndrome
);
  localparam int unsigned SEG_W     = $clog2(N_SEGS);
  localparam int unsigned IDX_W     = $clog2(N_ENTRIES);
  localparam int unsigned ENT_SH    = $clog2(ENTRY_BYTES);
  localparam int unsigned GRP_SH    = $clog2(N_ENTRIES * ENTRY_BYTES);
  localparam int unsigned W1_OFS    = ENTRY_BYTES / 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

  // Descriptor file unpacked for indexing
  logic [31:0] seg_arr [N_SEGS];
  for (genvar s = 0; s < N_SEGS; s++) begin : g_seg
    assign seg_arr[s] = seg_file[s*32 +: 32];
  end

  // State registers
  walk_state_e       state_q, state_d;
  logic [31:0]       ea_q, ea_d;
  logic [31:0]       desc_q, desc_d;
  logic              store_q, store_d;
  logic              fetch_q, fetch_d;
  logic              user_q, user_d;
  logic              pass_q, pass_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              wait_q, wait_d;
  logic [31:0]       w0_q, w0_d;
  logic [31:0]       w1_q, w1_d;
  logic              rec_valid_q, rec_valid_d;
  logic              rec_grant_q, rec_grant_d;
  logic [31:0]       rec_w1_q, rec_w1_d;
  logic [PERM_W-1:0] rec_perm_q, rec_perm_d;
  logic [31:0]       rec_addr_q, rec_addr_d;
  logic              res_fault_q, res_fault_d;
  logic [PPN_W-1:0]  res_ppn_q, res_ppn_d;
  logic [PERM_W-1:0] res_perm_q, res_perm_d;
  logic [31:0]       res_syn_q, res_syn_d;

  // Segment decode of the latched request
  logic              seg_key, seg_nx, seg_direct;
  logic [VSID_W-1:0] seg_hash;
  logic [31:0]       seg_tag;

  hpt_seg_decode #(
    .EA_W    (32),
    .PG_BITS (PG_BITS),
    .SEG_W   (SEG_W),
    .VSID_W  (VSID_W)
  ) i_seg_decode (
    .desc    (desc_q),
    .ea      (ea_q),
    .user    (user_q),
    .key     (seg_key),
    .no_exec (seg_nx),
    .direct  (seg_direct),
    .hash    (seg_hash),
    .tag     (seg_tag)
  );

  // Entry address for the current pass and index
  logic [31:0] hash_sel, grp_off, entry_addr;
  assign hash_sel   = pass_q ? ~(32'(seg_hash)) : 32'(seg_hash);
  assign grp_off    = (hash_sel << GRP_SH) & tbl_mask;
  assign entry_addr = tbl_base + grp_off + (32'(idx_q) << ENT_SH);

  // Entry evaluation
  logic              pte_match, pte_grant;
  logic [PERM_W-1:0] pte_perm;

  hpt_pte_eval i_pte_eval (
    .w0       (w0_q),
    .w1       (w1_q),
    .pass     (pass_q),
    .tag      (seg_tag),
    .key      (seg_key),
    .no_exec  (seg_nx),
    .is_fetch (fetch_q),
    .is_store (store_q),
    .match    (pte_match),
    .perm     (pte_perm),
    .grant    (pte_grant)
  );

  // Referenced / changed update of the selected entry
  logic [31:0]       fu_w1;
  logic              fu_write;
  logic [PERM_W-1:0] fu_perm;

  hpt_flag_update i_flag_update (
    .w1_old     (rec_w1_q),
    .is_store   (store_q),
    .granted    (rec_grant_q),
    .perm_in    (rec_perm_q),
    .w1_new     (fu_w1),
    .need_write (fu_write),
    .perm_out   (fu_perm)
  );

  logic        early_fault;
  fault_kind_e early_kind;
  assign early_fault = seg_direct | (fetch_q & seg_nx);
  assign early_kind  = seg_direct ? FK_DIRECT : FK_NOEXEC;

  // Next-state logic
  always_comb begin
    state_d     = state_q;
    ea_d        = ea_q;
    desc_d      = desc_q;
    store_d     = store_q;
    fetch_d     = fetch_q;
    user_d      = user_q;
    pass_d      = pass_q;
    idx_d       = idx_q;
    wait_d      = wait_q;
    w0_d        = w0_q;
    w1_d        = w1_q;
    rec_valid_d = rec_valid_q;
    rec_grant_d = rec_grant_q;
    rec_w1_d    = rec_w1_q;
    rec_perm_d  = rec_perm_q;
    rec_addr_d  = rec_addr_q;
    res_fault_d = res_fault_q;
    res_ppn_d   = res_ppn_q;
    res_perm_d  = res_perm_q;
    res_syn_d   = res_syn_q;
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = entry_addr;
    mem_req_wdata = '0;

    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ea_d        = req_ea;
          desc_d      = seg_arr[req_ea[31 -: SEG_W]];
          fetch_d     = req_fetch;
          store_d     = req_store & ~req_fetch;
          user_d      = req_user;
          pass_d      = 1'b0;
          idx_d       = '0;
          wait_d      = 1'b0;
          rec_valid_d = 1'b0;
          rec_grant_d = 1'b0;
          state_d     = ST_RD_W0;
        end
      end

      ST_RD_W0: begin
        if (early_fault) begin
          res_fault_d = 1'b1;
          res_ppn_d   = '0;
          res_perm_d  = '0;
          res_syn_d   = fault_syndrome(early_kind, fetch_q, store_q);
          state_d     = ST_DONE;
        end else if (!wait_q) begin
          mem_req_valid = 1'b1;
          if (mem_req_ready) wait_d = 1'b1;
        end else if (mem_rsp_valid) begin
          w0_d    = mem_rsp_rdata;
          wait_d  = 1'b0;
          state_d = ST_RD_W1;
        end
      end

      ST_RD_W1: begin
        mem_req_addr = entry_addr + 32'(W1_OFS);
        if (!pte_match) begin
          state_d = ST_CHECK;
        end else if (!wait_q) begin
          mem_req_valid = 1'b1;
          if (mem_req_ready) wait_d = 1'b1;
        end else if (mem_rsp_valid) begin
          w1_d    = mem_rsp_rdata;
          wait_d  = 1'b0;
          state_d = ST_CHECK;
        end
      end

      ST_CHECK: begin
        if (pte_match) begin
          rec_valid_d = 1'b1;
          rec_grant_d = pte_grant;
          rec_w1_d    = w1_q;
          rec_perm_d  = pte_perm;
          rec_addr_d  = entry_addr + 32'(W1_OFS);
        end
        if (pte_match && pte_grant) begin
          state_d = ST_WBACK;
        end else if (idx_q != LAST_IDX) begin
          idx_d   = idx_q + 1'b1;
          state_d = ST_RD_W0;
        end else if (!pass_q) begin
          pass_d  = 1'b1;
          idx_d   = '0;
          state_d = ST_RD_W0;
        end else if (rec_valid_d) begin
          state_d = ST_WBACK;
        end else begin
          res_fault_d = 1'b1;
          res_ppn_d   = '0;
          res_perm_d  = '0;
          res_syn_d   = fault_syndrome(FK_NOMATCH, fetch_q, store_q);
          state_d     = ST_DONE;
        end
      end

      ST_WBACK: begin
        mem_req_addr  = rec_addr_q;
        mem_req_wdata = fu_w1;
        mem_req_write = fu_write;
        mem_req_valid = fu_write;
        if (!fu_write || mem_req_ready) begin
          if (rec_grant_q) begin
            res_fault_d = 1'b0;
            res_ppn_d   = rec_w1_q[31 -: PPN_W];
            res_perm_d  = fu_perm;
            res_syn_d   = '0;
          end else begin
            res_fault_d = 1'b1;
            res_ppn_d   = '0;
            res_perm_d  = '0;
            res_syn_d   = fault_syndrome(FK_PROT, fetch_q, store_q);
          end
          state_d = ST_DONE;
        end
      end

      ST_DONE: state_d = ST_IDLE;

      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      ea_q        <= '0;
      desc_q      <= '0;
      store_q     <= 1'b0;
      fetch_q     <= 1'b0;
      user_q      <= 1'b0;
      pass_q      <= 1'b0;
      idx_q       <= '0;
      wait_q      <= 1'b0;
      w0_q        <= '0;
      w1_q        <= '0;
      rec_valid_q <= 1'b0;
      rec_grant_q <= 1'b0;
      rec_w1_q    <= '0;
      rec_perm_q  <= '0;
      rec_addr_q  <= '0;
      res_fault_q <= 1'b0;
      res_ppn_q   <= '0;
      res_perm_q  <= '0;
      res_syn_q   <= '0;
    end else begin
      state_q     <= state_d;
      ea_q        <= ea_d;
      desc_q      <= desc_d;
      store_q     <= store_d;
      fetch_q     <= fetch_d;
      user_q      <= user_d;
      pass_q      <= pass_d;
      idx_q       <= idx_d;
      wait_q      <= wait_d;
      w0_q        <= w0_d;
      w1_q        <= w1_d;
      rec_valid_q <= rec_valid_d;
      rec_grant_q <= rec_grant_d;
      rec_w1_q    <= rec_w1_d;
      rec_perm_q  <= rec_perm_d;
      rec_addr_q  <= rec_addr_d;
      res_fault_q <= res_fault_d;
      res_ppn_q   <= res_ppn_d;
      res_perm_q  <= res_perm_d;
      res_syn_q   <= res_syn_d;
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign done_valid    = (state_q == ST_DONE);
  assign done_fault    = res_fault_q;
  assign done_ppn      = res_ppn_q;
  assign done_perm     = res_perm_q;
  assign done_syndrome = res_syn_q;

  // Assertions
  p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  p_no_req_while_waiting_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q && !mem_rsp_valid |-> !mem_req_valid);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  p_fault_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_fault |-> done_perm == '0 && done_ppn == '0);

  p_wb_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata[REF_BIT]);

  p_nx_noread_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_RD_W0 && fetch_q && seg_nx |-> !mem_req_valid);

  p_pass_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass_q) |-> $past(idx_q) == LAST_IDX);

endmodule

// File: tb/test_hpt_walker.sv
module test_hpt_walker;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 1024;
  localparam logic [31:0] BASE = 32'h0000_0400;
  localparam logic [31:0] MASK = 32'h0000_03C0;

  logic clk, rst_n;
  logic req_valid, req_ready, req_store, req_fetch, req_user;
  logic [31:0] req_ea;
  logic [511:0] seg_file;
  logic mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_rdata;
  logic done_valid, done_fault;
  logic [19:0] done_ppn;
  logic [2:0] done_perm;
  logic [31:0] done_syndrome;

  hpt_walker i_hpt_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea),
    .req_store(req_store), .req_fetch(req_fetch), .req_user(req_user),
    .seg_file(seg_file), .tbl_base(BASE), .tbl_mask(MASK),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .done_valid(done_valid),
    .done_fault(done_fault), .done_ppn(done_ppn), .done_perm(done_perm),
    .done_syndrome(done_syndrome)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Memory model
  logic [31:0] mem [MEM_WORDS];
  logic        bd_we, bd_clr, cnt_clr, stall_en;
  logic [31:0] bd_addr, bd_data;
  int          n_rd, n_wr;
  logic [31:0] first_rd, last_wr_addr, last_wr_data;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (bd_clr) for (int i = 0; i < MEM_WORDS; i++) mem[i] <= '0;
    if (bd_we) mem[bd_addr[11:2]] <= bd_data;
    if (cnt_clr) begin
      n_rd <= 0; n_wr <= 0; first_rd <= '0;
    end else if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        mem[mem_req_addr[11:2]] <= mem_req_wdata;
        n_wr <= n_wr + 1;
        last_wr_addr <= mem_req_addr;
        last_wr_data <= mem_req_wdata;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem[mem_req_addr[11:2]];
        if (n_rd == 0) first_rd <= mem_req_addr;
        n_rd <= n_rd + 1;
      end
    end
    mem_req_ready <= stall_en ? ~mem_req_ready : 1'b1;
  end

  int n_checks, n_errors;
  logic saw_busy, timed_out;
  logic r_fault; logic [19:0] r_ppn; logic [2:0] r_perm; logic [31:0] r_syn;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_desc(logic ds, logic ks, logic ku,
                                          logic nx, logic [23:0] vsid);
    return {ds, ks, ku, nx, 4'b0, vsid};
  endfunction

  function automatic logic [31:0] ent_addr(logic [23:0] vsid, logic [15:0] pidx,
                                           logic pass, int idx);
    logic [31:0] h;
    h = {8'b0, vsid ^ {8'b0, pidx}};
    if (pass) h = ~h;
    return BASE + ((h << 6) & MASK) + 32'(idx * 8);
  endfunction

  task automatic put_word(logic [31:0] a, logic [31:0] d);
    @(negedge clk); bd_we = 1'b1; bd_addr = a; bd_data = d;
    @(negedge clk); bd_we = 1'b0;
  endtask

  task automatic put_pte(logic [23:0] vsid, logic [15:0] pidx, logic pass,
                         int idx, logic hbit, logic [19:0] rpn, logic r,
                         logic c, logic [1:0] pp);
    logic [31:0] a;
    a = ent_addr(vsid, pidx, pass, idx);
    put_word(a, {1'b1, vsid, hbit, pidx[15:10]});
    put_word(a + 4, {rpn, 3'b0, r, c, 5'b0, pp});
  endtask

  task automatic clear_mem();
    @(negedge clk); bd_clr = 1'b1;
    @(negedge clk); bd_clr = 1'b0;
  endtask

  task automatic walk(logic [31:0] ea, logic st, logic fe, logic us);
    int cyc;
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    req_ea = ea; req_store = st; req_fetch = fe; req_user = us; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    saw_busy = 1'b0; timed_out = 1'b0; cyc = 0;
    while (!done_valid && cyc < 2000) begin
      if (!req_ready) saw_busy = 1'b1;
      @(negedge clk); cyc++;
    end
    if (!done_valid) begin
      timed_out = 1'b1;
      n_checks++; n_errors++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    r_fault = done_fault; r_ppn = done_ppn; r_perm = done_perm; r_syn = done_syndrome;
    @(negedge clk);
    chk("R11 pulse", {31'b0, done_valid}, 32'd0);
  endtask

  function automatic logic [31:0] mk_ea(logic [3:0] seg, logic [15:0] pidx);
    return {seg, pidx, 12'h000};
  endfunction

  // Scenarios
  task automatic t_reset();
    chk("R11 reset req_ready", {31'b0, req_ready}, 32'd1);
    chk("R11 reset done_valid", {31'b0, done_valid}, 32'd0);
    chk("R11 reset mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
  endtask

  task automatic t_primary_hit(logic stall);
    logic [23:0] v; logic [15:0] p; logic [31:0] a;
    v = 24'h012345; p = 16'hABCD;
    clear_mem();
    seg_file[3*32 +: 32] = mk_desc(0, 0, 0, 0, v);
    put_pte(v, p, 0, 2, 0, 20'hBEEF1, 0, 0, 2'd2);
    stall_en = stall;
    walk(mk_ea(4'd3, p), 0, 0, 0);
    stall_en = 1'b0;
    a = ent_addr(v, p, 0, 2);
    chk("R2 first read address", first_rd, ent_addr(v, p, 0, 0));
    chk("R3 reads (w1 only on match)", 32'(n_rd), 32'd4);
    chk("R10 busy while walking", {31'b0, saw_busy}, 32'd1);
    chk("R11 ppn", {12'b0, r_ppn}, 32'h000BEEF1);
    chk("R6 load keeps write off", {29'b0, r_perm}, 32'd5);
    chk("R6 one write-back", 32'(n_wr), 32'd1);
    chk("R6 write-back address", last_wr_addr, a + 4);
    chk("R6 referenced set", last_wr_data, {20'hBEEF1, 3'b0, 1'b1, 1'b0, 5'b0, 2'd2});
  endtask

  task automatic t_store_changed();
    logic [23:0] v; logic [15:0] p;
    v = 24'h012345; p = 16'hABCD;
    walk(mk_ea(4'd3, p), 1, 0, 0);
    chk("R6 store grant perm", {29'b0, r_perm}, 32'd7);
    chk("R6 store writes changed", last_wr_data, {20'hBEEF1, 3'b0, 1'b1, 1'b1, 5'b0, 2'd2});
    chk("R6 store write count", 32'(n_wr), 32'd1);
    walk(mk_ea(4'd3, p), 1, 0, 0);
    chk("R6 no write when unchanged", 32'(n_wr), 32'd0);
    chk("R6 second store fault flag", {31'b0, r_fault}, 32'd0);
  endtask

  task automatic t_keys();
    logic [23:0] v; logic [15:0] p;
    v = 24'h00F0F0; p = 16'h1234;
    clear_mem();
    seg_file[5*32 +: 32] = mk_desc(0, 0, 1, 0, v);
    put_pte(v, p, 0, 0, 0, 20'h11111, 1, 1, 2'd1);
    walk(mk_ea(4'd5, p), 1, 0, 0);
    chk("R1 supervisor key0 store ok", {31'b0, r_fault}, 32'd0);
    chk("R4 key0 pp1 perm", {29'b0, r_perm}, 32'd7);
    walk(mk_ea(4'd5, p), 1, 0, 1);
    chk("R1 user key1 store faults", {31'b0, r_fault}, 32'd1);
    chk("R7 store prot syndrome", r_syn, 32'h0A00_0000);
    walk(mk_ea(4'd5, p), 0, 0, 1);
    chk("R4 key1 pp1 load perm", {29'b0, r_perm}, 32'd5);
  endtask

  task automatic t_secondary();
    logic [23:0] v; logic [15:0] p;
    v = 24'h0A0A0A; p = 16'h4321;
    clear_mem();
    seg_file[7*32 +: 32] = mk_desc(0, 0, 0, 0, v);
    put_pte(v, p, 0, 0, 1, 20'h22222, 1, 1, 2'd2);
    put_pte(v, p, 1, 5, 1, 20'h33333, 0, 0, 2'd3);
    walk(mk_ea(4'd7, p), 0, 0, 0);
    chk("R3 wrong hash bit skipped; R5 secondary hit", {12'b0, r_ppn}, 32'h00033333);
    chk("R4 key0 pp3 perm", {29'b0, r_perm}, 32'd5);
    chk("R2 secondary write address", last_wr_addr, ent_addr(v, p, 1, 5) + 4);
  endtask

  task automatic t_violation_then_grant();
    logic [23:0] v; logic [15:0] p;
    v = 24'h077777; p = 16'h0F0F;
    clear_mem();
    seg_file[9*32 +: 32] = mk_desc(0, 0, 1, 0, v);
    put_pte(v, p, 0, 0, 0, 20'h44444, 1, 1, 2'd0);
    walk(mk_ea(4'd9, p), 0, 0, 1);
    chk("R7 load prot syndrome", r_syn, 32'h0800_0000);
    chk("R5 violation recorded", {31'b0, r_fault}, 32'd1);
    put_pte(v, p, 1, 3, 1, 20'h55555, 1, 1, 2'd2);
    walk(mk_ea(4'd9, p), 0, 0, 1);
    chk("R5 secondary grant after violation", {12'b0, r_ppn}, 32'h00055555);
    chk("R4 key1 pp2 perm", {29'b0, r_perm}, 32'd7);
    walk(mk_ea(4'd9, p), 0, 1, 1);
    chk("R4 fetch key1 pp0 exec only", {29'b0, r_perm}, 32'd4);
  endtask

  task automatic t_first_wins();
    logic [23:0] v; logic [15:0] p;
    v = 24'h000101; p = 16'h8000;
    clear_mem();
    seg_file[1*32 +: 32] = mk_desc(0, 0, 0, 0, v);
    put_pte(v, p, 0, 1, 0, 20'h66666, 1, 1, 2'd2);
    put_pte(v, p, 0, 4, 0, 20'h77777, 1, 1, 2'd2);
    walk(mk_ea(4'd1, p), 0, 0, 0);
    chk("R5 first grant wins", {12'b0, r_ppn}, 32'h00066666);
  endtask

  task automatic t_nomatch();
    logic [23:0] v; logic [15:0] p;
    v = 24'h0ABCDE; p = 16'h0001;
    clear_mem();
    seg_file[2*32 +: 32] = mk_desc(0, 0, 0, 0, v);
    walk(mk_ea(4'd2, p), 0, 0, 0);
    chk("R7 load no match", r_syn, 32'h4000_0000);
    chk("R5 both passes scanned", 32'(n_rd), 32'd16);
    walk(mk_ea(4'd2, p), 1, 0, 0);
    chk("R7 store no match", r_syn, 32'h4200_0000);
    walk(mk_ea(4'd2, p), 0, 1, 0);
    chk("R8 fetch no match", r_syn, 32'h4000_0000);
  endtask

  task automatic t_noexec_direct();
    seg_file[4*32 +: 32] = mk_desc(0, 0, 0, 1, 24'h000444);
    walk(mk_ea(4'd4, 16'h0000), 0, 1, 0);
    chk("R8 no-exec fetch syndrome", r_syn, 32'h1000_0000);
    chk("R8 no-exec no reads", 32'(n_rd), 32'd0);
    seg_file[6*32 +: 32] = mk_desc(1, 0, 0, 0, 24'h000666);
    walk(mk_ea(4'd6, 16'h0000), 0, 0, 0);
    chk("R9 direct load syndrome", r_syn, 32'h0400_0000);
    chk("R9 direct no reads", 32'(n_rd), 32'd0);
    walk(mk_ea(4'd6, 16'h0000), 1, 0, 0);
    chk("R9 direct store syndrome", r_syn, 32'h0600_0000);
    walk(mk_ea(4'd6, 16'h0000), 0, 1, 0);
    chk("R9 direct fetch syndrome", r_syn, 32'h1000_0000);
    chk("R11 fault ppn zero", {12'b0, r_ppn}, 32'd0);
  endtask

  initial begin
    n_checks = 0; n_errors = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_fetch = 1'b0;
    req_user = 1'b0; req_ea = '0; seg_file = '0;
    bd_we = 1'b0; bd_clr = 1'b0; cnt_clr = 1'b0; stall_en = 1'b0;
    bd_addr = '0; bd_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_primary_hit(1'b0);
    t_store_changed();
    t_keys();
    t_secondary();
    t_violation_then_grant();
    t_first_wins();
    t_nomatch();
    t_noexec_direct();
    t_primary_hit(1'b1);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule